// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Generator

This block is a register-mapped pulse-width modulator with two independent channels. Software programs one shared control word and one period/duty word per channel through a simple valid/write/address/data port; reads return register contents combinationally from the address. Each channel divides the source clock by a coded prescale factor. Every divided tick advances a counter that sets the output pattern. Each channel has its own enable, clock gate, active level and a bypass that puts the undivided source clock on the pin.

Period/duty writes land in a shadow copy. The running channel takes up the shadow copy only at its next period boundary, so the current period always completes with its old settings. A per-channel ready flag in the control word shows that a transfer is still outstanding. A stopped channel takes the new values on the next clock.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset every register reads 0 and both outputs sit at the inactive level of active-level 0, which is 1.
- R2: Control word at byte address 0x0. Channel c owns bits 15*c+9 .. 15*c: [3:0] prescale code, [4] enable, [5] active level, [6] clock gate, [7] mode, [8] pulse start, [9] bypass. All of these read back as written. The ready flag of channel c reads at bit 28+c and ignores writes. Every other bit reads 0.
- R3: The period/duty word of channel c sits at byte address 0x4+4*c. Bits [31:16] hold the period length minus one, in prescaled ticks. Bits [15:0] hold the duty count. A read returns the last value written.
- R4: The prescale codes give these divisors: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1.
- R5: While a channel runs, its output is active while the counter is below the duty count and inactive for the rest of the period. A duty of 0 gives a constant inactive level. A duty at or above the period length gives a constant active level.
- R6: Active level 1 makes the active state high. Active level 0 inverts the output.
- R7: A channel runs only when both its enable bit and its gate bit are 1. Otherwise its counter holds and its output stays at the inactive level.
- R8: Codes 5, 6, 7, 13 and 14 are invalid. With an invalid code the channel does not run and its output stays inactive.
- R9: A period/duty write sets the channel's ready flag. A running channel copies the shadow into its working registers at the next period boundary and clears the flag then. A stopped channel does so on the next clock.
- R10: With bypass set, the channel output equals the source clock. All other settings of that channel are ignored.
- R11: The mode and pulse-start bits are stored and have no effect on the output.
- R12: Each channel's settings affect only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe for writes |
| bus_write | input | 1 | 1 for a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
A register write takes effect at the clock edge that captures it. Reads come combinationally from registers, so the bench reads 1 ns after the falling edge that follows the capture. A stopped channel clears its ready flag one edge later, and the bench samples once before that edge and once after it. A running channel with prescale 120 and period 4 reaches its boundary 480 cycles after it is enabled, so the ready flag is checked about 200 cycles in (still set) and about 600 cycles in (cleared). Waveform checks wait one prescaled tick so the counter settles. They then count high samples at falling edges over a window that spans a whole number of periods, which makes the expected count independent of the starting phase. Bypass is checked 1 ns after each clock edge, in both clock phases.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int DIV_W  = 17;
  localparam int CODE_W = 4;

  // Per-channel control group, LSB first: code, enable, level, gate, mode, pulse, bypass
  typedef struct packed {
    logic              bypass;
    logic              pulse;
    logic              mode;
    logic              gate;
    logic              lvl;
    logic              en;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;

  // Prescale divisor for a code; 0 marks an invalid code
  function automatic logic [DIV_W-1:0] code_divisor(input logic [CODE_W-1:0] c);
    logic [DIV_W-1:0] d;
    case (c)
      4'd0:    d = DIV_W'(120);
      4'd1:    d = DIV_W'(180);
      4'd2:    d = DIV_W'(240);
      4'd3:    d = DIV_W'(360);
      4'd4:    d = DIV_W'(480);
      4'd8:    d = DIV_W'(12000);
      4'd9:    d = DIV_W'(24000);
      4'd10:   d = DIV_W'(36000);
      4'd11:   d = DIV_W'(48000);
      4'd12:   d = DIV_W'(72000);
      4'd15:   d = DIV_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int GRP    = 15,
  parameter int RDY    = 28
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [NCH-1:0]               pend,
  input  logic [NCH-1:0][DATA_W-1:0]   shadow_word,
  output chan_cfg_t [NCH-1:0]          cfg,
  output logic [NCH-1:0]               pd_wr,
  output logic [DATA_W-1:0]            pd_data,
  output logic [DATA_W-1:0]            bus_rdata
);

  localparam int CFG_W = $bits(chan_cfg_t);

  chan_cfg_t [NCH-1:0] cfg_q, cfg_d;
  logic                ctrl_wr;

  assign ctrl_wr = bus_valid & bus_write & (bus_addr == '0);
  assign pd_data = bus_wdata;

  always_comb begin
    cfg_d = cfg_q;
    for (int ch = 0; ch < NCH; ch++) begin
      cfg_d[ch] = bus_wdata[ch*GRP +: CFG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctrl_wr) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  for (genvar g = 0; g < NCH; g++) begin : g_pd_dec
    assign pd_wr[g] = bus_valid & bus_write & (bus_addr == ADDR_W'(4 + 4*g));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bus_rdata[ch*GRP +: CFG_W] = cfg_q[ch];
        bus_rdata[RDY + ch]        = pend[ch];
      end
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == ADDR_W'(4 + 4*ch)) begin
        bus_rdata = shadow_word[ch];
      end
    end
  end

endmodule

// File: rtl/pwm2_prescale.sv
module pwm2_prescale
  import pwm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              code_ok,
  output logic              tick
);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] div_q, div_d;

  assign divisor = code_divisor(code);
  assign code_ok = |divisor;
  assign tick    = run & (div_q == (divisor - DIV_W'(1)));

  always_comb begin
    if (!run) begin
      div_d = '0;
    end else if (tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code,
  input  logic                 en,
  input  logic                 lvl,
  input  logic                 gate,
  input  logic                 pd_wr,
  input  logic [2*CNT_W-1:0]   pd_data,
  output logic                 wave,
  output logic                 run,
  output logic                 code_ok,
  output logic                 pending,
  output logic [2*CNT_W-1:0]   shadow_word,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     duty_o
);

  logic             tick;
  logic             boundary, load, active;
  logic [CNT_W-1:0] sh_prd_q, sh_duty_q, sh_prd_d, sh_duty_d;
  logic [CNT_W-1:0] wk_prd_q, wk_duty_q, wk_prd_d, wk_duty_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;

  assign run = en & gate & code_ok;

  pwm2_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .code    (code),
    .code_ok (code_ok),
    .tick    (tick)
  );

  assign boundary = tick & (cnt_q >= wk_prd_q);
  assign load     = pend_q & (boundary | ~run);

  always_comb begin
    sh_prd_d  = sh_prd_q;
    sh_duty_d = sh_duty_q;
    pend_d    = pend_q;
    wk_prd_d  = wk_prd_q;
    wk_duty_d = wk_duty_q;
    cnt_d     = cnt_q;
    if (load) begin
      wk_prd_d  = sh_prd_q;
      wk_duty_d = sh_duty_q;
      pend_d    = 1'b0;
    end
    if (pd_wr) begin
      sh_prd_d  = pd_data[2*CNT_W-1:CNT_W];
      sh_duty_d = pd_data[CNT_W-1:0];
      pend_d    = 1'b1;
    end
    if (tick) begin
      cnt_d = boundary ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prd_q  <= '0;
      sh_duty_q <= '0;
      pend_q    <= 1'b0;
    end else if (pd_wr | load) begin
      sh_prd_q  <= sh_prd_d;
      sh_duty_q <= sh_duty_d;
      pend_q    <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_prd_q  <= '0;
      wk_duty_q <= '0;
    end else if (load) begin
      wk_prd_q  <= wk_prd_d;
      wk_duty_q <= wk_duty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign active      = cnt_q < wk_duty_q;
  assign wave        = run ? (lvl ? active : ~active) : ~lvl;
  assign pending     = pend_q;
  assign shadow_word = {sh_prd_q, sh_duty_q};
  assign cnt_o       = cnt_q;
  assign duty_o      = wk_duty_q;

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int PD_W = 2 * CNT_W;

  logic [1:0]                  rst_pipe;
  logic                        rst_sn;
  chan_cfg_t [NCH-1:0]         cfg;
  logic [NCH-1:0]              pd_wr, pend, run, wave, lvl_v, byp_v, ok_v;
  logic [DATA_W-1:0]           pd_data;
  logic [NCH-1:0][DATA_W-1:0]  shw;
  logic [NCH-1:0][CNT_W-1:0]   cnt_v, duty_v;

  // Reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  pwm2_regs #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sn),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pend        (pend),
    .shadow_word (shw),
    .cfg         (cfg),
    .pd_wr       (pd_wr),
    .pd_data     (pd_data),
    .bus_rdata   (bus_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [PD_W-1:0] sw;

    pwm2_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_sn),
      .code        (cfg[g].code),
      .en          (cfg[g].en),
      .lvl         (cfg[g].lvl),
      .gate        (cfg[g].gate),
      .pd_wr       (pd_wr[g]),
      .pd_data     (pd_data[PD_W-1:0]),
      .wave        (wave[g]),
      .run         (run[g]),
      .code_ok     (ok_v[g]),
      .pending     (pend[g]),
      .shadow_word (sw),
      .cnt_o       (cnt_v[g]),
      .duty_o      (duty_v[g])
    );

    assign shw[g]     = DATA_W'(sw);
    assign lvl_v[g]   = cfg[g].lvl;
    assign byp_v[g]   = cfg[g].bypass;
    assign pwm_out[g] = cfg[g].bypass ? clk : wave[g];
  end

endmodule

// File: rtl/pwm2_chk.sv
module pwm2_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            pend,
  input logic [NCH-1:0]            pd_wr,
  input logic [NCH-1:0]            lvl_v,
  input logic [NCH-1:0]            byp_v,
  input logic [NCH-1:0]            ok_v,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v,
  input logic [NCH-1:0][CNT_W-1:0] duty_v
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R9: a write raises the ready flag
    a_r9_write_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pd_wr[c] |=> pend[c]);

    // R9: a stopped channel takes its shadow on the next clock
    a_r9_idle_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] && !run[c] && !pd_wr[c]) |=> !pend[c]);

    // R7: counter holds while the channel is stopped
    a_r7_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |=> $stable(cnt_v[c]));

    // R7: stopped channel drives its inactive level
    a_r7_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !byp_v[c]) |-> (pwm_out[c] == !lvl_v[c]));

    // R8: invalid code keeps the pin inactive
    a_r8_bad_code_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      (!ok_v[c] && !byp_v[c]) |-> (pwm_out[c] == !lvl_v[c]));

    // R5: zero duty never shows the active level
    a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !byp_v[c] && (duty_v[c] == '0)) |-> (pwm_out[c] == !lvl_v[c]));
  end

endmodule

bind pwm2_ctrl pwm2_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .pwm_out (pwm_out),
  .run     (run),
  .pend    (pend),
  .pd_wr   (pd_wr),
  .lvl_v   (lvl_v),
  .byp_v   (byp_v),
  .ok_v    (ok_v),
  .cnt_v   (cnt_v),
  .duty_v  (duty_v)
);

// File: tb/test_pwm2_ctrl.sv
`timescale 1ns/1ps
module test_pwm2_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] ctl_img = '0;

  always #2.5 clk = ~clk;

  pwm2_ctrl i_pwm2_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  function automatic int bdiv(input int code);
    case (code)
      0: return 120;  1: return 180;  2: return 240;  3: return 360;  4: return 480;
      8: return 12000; 9: return 24000; 10: return 36000; 11: return 48000;
      12: return 72000; 15: return 1;
      default: return 1;
    endcase
  endfunction

  function automatic logic [9:0] grp(input int code, input bit en, lvl, gate, mode, pulse, byp);
    return {byp, pulse, mode, gate, lvl, en, 4'(code)};
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cfg(input int ch, input int code, input bit en, lvl, gate, mode, pulse, byp,
                     input int prd_m1, input int duty);
    ctl_img[ch*15 +: 10] = '0;
    wr(4'h0, ctl_img);
    wr(4'(4 + 4*ch), {16'(prd_m1), 16'(duty)});
    repeat (2) @(negedge clk);
    ctl_img[ch*15 +: 10] = grp(code, en, lvl, gate, mode, pulse, byp);
    wr(4'h0, ctl_img);
    repeat (bdiv(code) * 2 + 4) @(negedge clk);
  endtask

  task automatic meas(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic stop_all();
    ctl_img = '0;
    wr(4'h0, ctl_img);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 ctrl after reset", v, 0);
    rd(4'h4, v); chk("R1 ch0 pd after reset", v, 0);
    rd(4'h8, v); chk("R1 ch1 pd after reset", v, 0);
    chk("R1 outputs after reset", pwm_out, 2'b11);
  endtask

  task automatic t_shadow_running();
    logic [31:0] v;
    int hi;
    wr(4'h4, {16'd3, 16'd2});
    @(negedge clk);
    ctl_img[9:0] = grp(0, 1, 1, 1, 0, 0, 0);
    wr(4'h0, ctl_img);
    wr(4'h4, {16'd1, 16'd1});
    rd(4'h0, v); chk("R9 ready set after write", v[28], 1);
    repeat (200) @(negedge clk);
    rd(4'h0, v); chk("R9 ready held until boundary", v[28], 1);
    repeat (400) @(negedge clk);
    rd(4'h0, v); chk("R9 ready cleared at boundary", v[28], 0);
    meas(0, 480, hi); chk("R4 code0 div120 new period", hi, 240);
    stop_all();
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R2 ctrl readback mask", v, 32'h01FF_83FF);
    stop_all();
    rd(4'h0, v); chk("R2 ctrl cleared", v, 0);
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, v); chk("R3 ch1 pd readback", v, 32'h1234_5678);
    rd(4'h4, v); chk("R3 ch0 pd readback", v, 32'h0001_0001);
  endtask

  task automatic t_idle_transfer();
    logic [31:0] v;
    wr(4'h8, {16'd4, 16'd1});
    rd(4'h0, v); chk("R9 stopped ready set", v[29], 1);
    @(negedge clk);
    rd(4'h0, v); chk("R9 stopped ready cleared next clock", v[29], 0);
    wr(4'h0, 32'h3000_0000);
    rd(4'h0, v); chk("R2 ready bits ignore writes", v, 0);
  endtask

  task automatic t_wave();
    int hi;
    cfg(0, 15, 1, 1, 1, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R5 duty 2 of 5", hi, 20);
    cfg(0, 15, 1, 1, 1, 0, 0, 0, 4, 0);
    meas(0, 50, hi); chk("R5 duty zero", hi, 0);
    cfg(0, 15, 1, 1, 1, 0, 0, 0, 4, 9);
    meas(0, 50, hi); chk("R5 duty above period", hi, 50);
    cfg(0, 15, 1, 1, 1, 0, 0, 0, 4, 5);
    meas(0, 50, hi); chk("R5 duty equal period", hi, 50);
    cfg(0, 15, 1, 0, 1, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R6 inverted level", hi, 30);
    cfg(0, 15, 1, 1, 1, 1, 1, 0, 4, 2);
    meas(0, 50, hi); chk("R11 mode and pulse no effect", hi, 20);
  endtask

  task automatic t_stopped();
    int hi;
    cfg(0, 15, 1, 0, 0, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R7 gate off inactive high", hi, 50);
    cfg(0, 15, 0, 1, 1, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R7 enable off inactive low", hi, 0);
    cfg(0, 5, 1, 1, 1, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R8 code 5 inactive", hi, 0);
    cfg(0, 13, 1, 0, 1, 0, 0, 0, 4, 2);
    meas(0, 50, hi); chk("R8 code 13 inactive high", hi, 50);
  endtask

  task automatic t_prescale();
    int hi;
    cfg(1, 2, 1, 1, 1, 0, 0, 0, 1, 1);
    meas(1, 960, hi); chk("R4 code2 div240", hi, 480);
    cfg(1, 8, 1, 1, 1, 0, 0, 0, 1, 1);
    meas(1, 48000, hi); chk("R4 code8 div12000", hi, 24000);
    stop_all();
  endtask

  task automatic t_bypass();
    cfg(0, 5, 0, 0, 0, 0, 0, 1, 4, 2);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R10 bypass follows clock high", pwm_out[0], 1);
      @(negedge clk); #1;
      chk("R10 bypass follows clock low", pwm_out[0], 0);
    end
    stop_all();
  endtask

  task automatic t_indep();
    int h0 = 0;
    int h1 = 0;
    cfg(0, 15, 1, 1, 1, 0, 0, 0, 4, 2);
    cfg(1, 15, 1, 1, 1, 0, 0, 0, 3, 1);
    repeat (20) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
    chk("R12 ch0 unaffected by ch1", h0, 8);
    chk("R12 ch1 own pattern", h1, 5);
    stop_all();
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_shadow_running();
    t_layout();
    t_idle_transfer();
    t_wave();
    t_stopped();
    t_prescale();
    t_bypass();
    t_indep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule